// File: doc/BRIEF.md
# Calorimeter Trigger Primitive Builder

This block turns raw front-end samples into trigger primitives for two calorimeter towers, once per bunch crossing. Each tower is read out at two depths, front and back, so four sample lanes enter together on every crossing. Each sample carries an 8-bit compressed energy code and a 2-bit capacitor tag. Every lane has its own writable 256-word table that maps the code to a 16-bit linear energy. A small tracking state machine watches the tag sequence of each lane.

For each tower the two linear depths are added. The sum is scaled down by a programmable right shift and clamped to 8 bits. A muon window then tags deposits whose energy falls between two programmable limits. The two tower results and an abort-gap marker form a 19-bit payload. Five single-error-correcting check bits protect the payload, which gives a 24-bit trigger word. The pipeline has a fixed latency of three clocks and accepts a new crossing on every clock. Lane order is: lane 0 tower A front, lane 1 tower A back, lane 2 tower B front, lane 3 tower B back. Lane n uses bits [8n+7:8n] of the code bus and bits [2n+1:2n] of the tag bus.

Top module: `trig_prim_builder`

## Requirements
- R1: `out_valid` goes high exactly three clocks after each clock on which `in_valid` is high, and stays low otherwise. One output word appears per input crossing.
- R2: A clock with `lut_we` high writes `lut_data` into entry `lut_addr` of the table of lane `lut_ch`. Later samples on that lane with that code use the new value as their linear energy.
- R3: With no error, the tower energy is (front + back) >> `cfg_shift`. It becomes 0xFF when that value exceeds 255 and is exact up to 255.
- R4: Each lane's tag checker has two states, SYNC and TRACK, and moves only on valid samples. SYNC→TRACK (transition "lock") accepts any tag without error and expects tag+1 mod 4 next. TRACK→TRACK ("advance") happens on a matching tag. TRACK→SYNC ("slip") happens on a mismatch and flags that sample as a capacitor error. Reset enters SYNC.
- R5: A capacitor error on either lane of a tower forces that tower's energy to 0xFF and its feature bit to 0 for that crossing.
- R6: Without error, a tower's feature bit is 1 exactly when `cfg_mu_lo` <= energy <= `cfg_mu_hi`, where energy is the 8-bit value after clamping.
- R7: Output bit 18 carries `in_abort` of the same crossing.
- R8: The word layout is: [7:0] tower A energy, [8] tower A feature, [16:9] tower B energy, [17] tower B feature, [18] abort flag, [23:19] check bits. Payload bit k sits at the k-th position, counting up from 3, among codeword positions 1..24 that are not powers of two. Check bit j (word bit 19+j) is the XOR of the payload bits whose position has bit j set. This makes the syndrome of every output word zero.
- R9: During reset and after it, until the first result, `out_valid` and `out_word` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | crossing clock |
| rst_n | input | 1 | active-low synchronous reset |
| in_valid | input | 1 | a crossing is present on the sample buses |
| in_code | input | 32 | four 8-bit energy codes, lane 0 in the low byte |
| in_cap | input | 8 | four 2-bit capacitor tags, lane 0 in the low bits |
| in_abort | input | 1 | this crossing lies in the beam abort gap |
| lut_we | input | 1 | table write strobe |
| lut_ch | input | 2 | lane whose table is written |
| lut_addr | input | 8 | table entry to write |
| lut_data | input | 16 | linear energy to store |
| cfg_shift | input | 4 | right shift applied to each tower sum |
| cfg_mu_lo | input | 8 | muon window lower limit |
| cfg_mu_hi | input | 8 | muon window upper limit |
| out_valid | output | 1 | `out_word` holds a result |
| out_word | output | 24 | protected two-tower trigger word |

## Verification
The window and saturation properties compare the output with the configuration one clock earlier. They therefore assume that `cfg_shift`, `cfg_mu_lo` and `cfg_mu_hi` change only while the pipeline is empty. The bench reconfigures only after a drain of several idle clocks. The table is assumed never to be written while a crossing is in flight, so the bench loads and patches tables only between streaming phases. Tags are sequential by default, with sparse deliberate slips, so that both the error and the resynchronization paths run.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
    localparam int CODE_W = 8;
    localparam int CAP_W  = 2;
    localparam int LIN_W  = 16;
    localparam int ET_W   = 8;
    localparam int PAY_W  = 2 * (ET_W + 1) + 1;
    localparam int CHK_W  = 5;
    localparam int WORD_W = PAY_W + CHK_W;

    typedef enum logic [0:0] {
        CAP_SYNC  = 1'b0,
        CAP_TRACK = 1'b1
    } cap_state_e;

    // single-error-correcting check bits over the payload
    function automatic logic [CHK_W-1:0] ham_check(input logic [PAY_W-1:0] d);
        logic [CHK_W-1:0] c;
        int k;
        c = '0;
        k = 0;
        for (int p = 1; p <= WORD_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                for (int b = 0; b < CHK_W; b++) begin
                    if (p[b]) c[b] = c[b] ^ d[k];
                end
                k++;
            end
        end
        return c;
    endfunction
endpackage

// File: rtl/tpb_lut.sv
module tpb_lut #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= mem[raddr];
    end
endmodule

// File: rtl/tpb_capcheck.sv
module tpb_capcheck
    import tpb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [CAP_W-1:0] cap,
    output logic             err
);
    cap_state_e       state_q, state_d;
    logic [CAP_W-1:0] exp_q, exp_d;
    logic             slip;

    always_comb begin
        state_d = state_q;
        exp_d   = exp_q;
        slip    = 1'b0;
        if (valid) begin
            unique case (state_q)
                CAP_SYNC: begin
                    exp_d   = cap + 1'b1;
                    state_d = CAP_TRACK;
                end
                CAP_TRACK: begin
                    if (cap != exp_q) begin
                        slip    = 1'b1;
                        state_d = CAP_SYNC;
                    end else begin
                        exp_d = cap + 1'b1;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAP_SYNC;
            exp_q   <= '0;
        end else begin
            state_q <= state_d;
            exp_q   <= exp_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= slip;
    end
endmodule

// File: rtl/tpb_tower.sv
module tpb_tower
    import tpb_pkg::*;
#(
    parameter int SHIFT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LIN_W-1:0]   lin_f,
    input  logic [LIN_W-1:0]   lin_b,
    input  logic               err_f,
    input  logic               err_b,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [ET_W-1:0]    mu_lo,
    input  logic [ET_W-1:0]    mu_hi,
    output logic               blk_err,
    output logic [ET_W-1:0]    et,
    output logic               feat
);
    localparam int SUM_W = LIN_W + 1;

    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] scaled;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q   <= '0;
            blk_err <= 1'b0;
        end else begin
            sum_q   <= SUM_W'(lin_f) + SUM_W'(lin_b);
            blk_err <= err_f | err_b;
        end
    end

    always_comb begin
        scaled = sum_q >> shift;
        if (blk_err || (|scaled[SUM_W-1:ET_W])) et = '1;
        else                                    et = scaled[ET_W-1:0];
        feat = !blk_err && (et >= mu_lo) && (et <= mu_hi);
    end
endmodule

// File: rtl/trig_prim_builder.sv
module trig_prim_builder
    import tpb_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int SHIFT_W = 4,
    parameter int CH_W    = $clog2(NCH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [NCH*CODE_W-1:0] in_code,
    input  logic [NCH*CAP_W-1:0]  in_cap,
    input  logic                  in_abort,
    input  logic                  lut_we,
    input  logic [CH_W-1:0]       lut_ch,
    input  logic [CODE_W-1:0]     lut_addr,
    input  logic [LIN_W-1:0]      lut_data,
    input  logic [SHIFT_W-1:0]    cfg_shift,
    input  logic [ET_W-1:0]       cfg_mu_lo,
    input  logic [ET_W-1:0]       cfg_mu_hi,
    output logic                  out_valid,
    output logic [WORD_W-1:0]     out_word
);
    localparam int NTW = NCH / 2;

    logic [LIN_W-1:0] lin [NCH];
    logic [NCH-1:0]   cap_err;
    logic [NTW-1:0]   s2_err;
    logic [ET_W-1:0]  tw_et [NTW];
    logic [NTW-1:0]   tw_feat;
    logic             v1, v2, a1, a2;
    logic [PAY_W-1:0] payload;

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        tpb_lut #(.ADDR_W(CODE_W), .DATA_W(LIN_W)) u_lut (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (lut_we && (lut_ch == CH_W'(i))),
            .waddr (lut_addr),
            .wdata (lut_data),
            .raddr (in_code[i*CODE_W +: CODE_W]),
            .rdata (lin[i])
        );
        tpb_capcheck u_cap (
            .clk   (clk),
            .rst_n (rst_n),
            .valid (in_valid),
            .cap   (in_cap[i*CAP_W +: CAP_W]),
            .err   (cap_err[i])
        );
    end

    for (genvar t = 0; t < NTW; t++) begin : g_tower
        tpb_tower #(.SHIFT_W(SHIFT_W)) u_tw (
            .clk     (clk),
            .rst_n   (rst_n),
            .lin_f   (lin[2*t]),
            .lin_b   (lin[2*t+1]),
            .err_f   (cap_err[2*t]),
            .err_b   (cap_err[2*t+1]),
            .shift   (cfg_shift),
            .mu_lo   (cfg_mu_lo),
            .mu_hi   (cfg_mu_hi),
            .blk_err (s2_err[t]),
            .et      (tw_et[t]),
            .feat    (tw_feat[t])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0;
            v2 <= 1'b0;
            a1 <= 1'b0;
            a2 <= 1'b0;
        end else begin
            v1 <= in_valid;
            v2 <= v1;
            a1 <= in_abort;
            a2 <= a1;
        end
    end

    assign payload = {a2, tw_feat[1], tw_et[1], tw_feat[0], tw_et[0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= v2;
            out_word  <= v2 ? {ham_check(payload), payload} : '0;
        end
    end
endmodule

// File: rtl/trig_prim_builder_chk.sv
module trig_prim_builder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_abort,
    input logic [7:0]  cfg_mu_lo,
    input logic [7:0]  cfg_mu_hi,
    input logic        out_valid,
    input logic [23:0] out_word,
    input logic [3:0]  cap_err,
    input logic [1:0]  s2_err,
    input logic        v2
);
    logic [1:0] cyc;

    always_ff @(posedge clk) begin
        if (!rst_n)         cyc <= '0;
        else if (cyc != 3)  cyc <= cyc + 1'b1;
    end

    function automatic logic [4:0] syndrome(input logic [23:0] w);
        logic [4:0] s;
        logic       bitv;
        int k;
        s = '0;
        k = 0;
        for (int p = 1; p <= 24; p++) begin
            if ((p & (p - 1)) == 0) begin
                bitv = w[19 + $clog2(p)];
            end else begin
                bitv = w[k];
                k++;
            end
            if (bitv) s = s ^ 5'(p);
        end
        return s;
    endfunction

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 3) |-> (out_valid == $past(in_valid, 3)));

    p_resync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|cap_err) && in_valid) |=> ((cap_err & $past(cap_err)) == 4'b0));

    p_err_sat_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (v2 && s2_err[0]) |=> (out_word[7:0] == 8'hFF && !out_word[8]));

    p_err_sat_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (v2 && s2_err[1]) |=> (out_word[16:9] == 8'hFF && !out_word[17]));

    p_window_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_word[8]) |->
        (out_word[7:0] >= $past(cfg_mu_lo) && out_word[7:0] <= $past(cfg_mu_hi)));

    p_window_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_word[17]) |->
        (out_word[16:9] >= $past(cfg_mu_lo) && out_word[16:9] <= $past(cfg_mu_hi)));

    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc == 3) && out_valid) |-> (out_word[18] == $past(in_abort, 3)));

    p_syndrome_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (syndrome(out_word) == 5'd0));

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_word == 24'd0));
endmodule

bind trig_prim_builder trig_prim_builder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_abort  (in_abort),
    .cfg_mu_lo (cfg_mu_lo),
    .cfg_mu_hi (cfg_mu_hi),
    .out_valid (out_valid),
    .out_word  (out_word),
    .cap_err   (cap_err),
    .s2_err    (s2_err),
    .v2        (v2)
);

// File: tb/trig_prim_builder_tb.sv
module trig_prim_builder_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_code;
    logic [7:0]  in_cap;
    logic        in_abort;
    logic        lut_we;
    logic [1:0]  lut_ch;
    logic [7:0]  lut_addr;
    logic [15:0] lut_data;
    logic [3:0]  cfg_shift;
    logic [7:0]  cfg_mu_lo;
    logic [7:0]  cfg_mu_hi;
    logic        out_valid;
    logic [23:0] out_word;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] tbl [4][256];
    logic [23:0] expq [$];
    bit          m_sync [4];
    logic [1:0]  m_exp  [4];
    logic [1:0]  gen    [4];

    always #2 clk = ~clk;

    trig_prim_builder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
        .in_cap(in_cap), .in_abort(in_abort), .lut_we(lut_we), .lut_ch(lut_ch),
        .lut_addr(lut_addr), .lut_data(lut_data), .cfg_shift(cfg_shift),
        .cfg_mu_lo(cfg_mu_lo), .cfg_mu_hi(cfg_mu_hi), .out_valid(out_valid),
        .out_word(out_word)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    // codeword built at positions 1..24, data at non-power-of-two positions
    function automatic logic [4:0] tb_checks(input logic [18:0] d);
        logic [24:0] cw;
        logic [4:0]  c;
        int k;
        cw = '0;
        k = 0;
        for (int p = 1; p <= 24; p++) begin
            if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16) begin
                cw[p] = d[k];
                k++;
            end
        end
        c = '0;
        for (int j = 0; j < 5; j++)
            for (int p = 1; p <= 24; p++)
                if (((p >> j) & 1) == 1) c[j] = c[j] ^ cw[p];
        return c;
    endfunction

    function automatic logic [15:0] tb_fill(input int ch, input int a);
        return 16'((a * a + ch * 97 * a) & 16'hFFFF);
    endfunction

    function automatic logic [1:0] cap_model(input logic [7:0] caps);
        logic [1:0] terr;
        logic [3:0] e;
        for (int c = 0; c < 4; c++) begin
            logic [1:0] t;
            t = caps[2*c +: 2];
            e[c] = 1'b0;
            if (m_sync[c]) begin
                m_sync[c] = 1'b0;
                m_exp[c]  = t + 2'd1;
            end else if (t != m_exp[c]) begin
                e[c]      = 1'b1;
                m_sync[c] = 1'b1;
            end else begin
                m_exp[c] = t + 2'd1;
            end
        end
        terr = {e[2] | e[3], e[0] | e[1]};
        return terr;
    endfunction

    function automatic logic [23:0] expect_word(input logic [31:0] codes, input logic [7:0] caps, input bit ab);
        logic [1:0]  terr;
        logic [7:0]  et [2];
        logic        ft [2];
        logic [18:0] pay;
        terr = cap_model(caps);
        for (int t = 0; t < 2; t++) begin
            int s;
            s = int'(tbl[2*t][codes[16*t +: 8]]) + int'(tbl[2*t+1][codes[16*t+8 +: 8]]);
            s = s >> cfg_shift;
            if (terr[t] || s > 255) et[t] = 8'hFF;
            else                    et[t] = 8'(s);
            ft[t] = !terr[t] && et[t] >= cfg_mu_lo && et[t] <= cfg_mu_hi;
        end
        pay = {ab, ft[1], et[1], ft[0], et[0]};
        return {tb_checks(pay), pay};
    endfunction

    task automatic check_out();
        logic [23:0] e;
        if (out_valid) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R1 unexpected out_valid", 32'(out_word), 32'd0);
            end else begin
                e = expq.pop_front();
                chk(out_word[7:0] == e[7:0], (e[7:0] == 8'hFF) ? "R4/R5 energy A" : "R3 energy A",
                    32'(out_word[7:0]), 32'(e[7:0]));
                chk(out_word[16:9] == e[16:9], (e[16:9] == 8'hFF) ? "R4/R5 energy B" : "R3 energy B",
                    32'(out_word[16:9]), 32'(e[16:9]));
                chk({out_word[17], out_word[8]} == {e[17], e[8]}, "R6 feature bits",
                    32'({out_word[17], out_word[8]}), 32'({e[17], e[8]}));
                chk(out_word[18] == e[18], "R7 abort flag", 32'(out_word[18]), 32'(e[18]));
                chk(out_word[23:19] == e[23:19], "R8 check bits", 32'(out_word[23:19]), 32'(e[23:19]));
            end
        end
    endtask

    task automatic step(input bit v, input logic [31:0] codes, input logic [7:0] caps, input bit ab);
        @(negedge clk);
        check_out();
        in_valid = v;
        in_code  = codes;
        in_cap   = caps;
        in_abort = ab;
        if (v) expq.push_back(expect_word(codes, caps, ab));
    endtask

    task automatic drain();
        for (int i = 0; i < 6; i++) step(1'b0, 32'd0, 8'd0, 1'b0);
        chk(expq.size() == 0, "R1 all results delivered", 32'(expq.size()), 32'd0);
    endtask

    task automatic wr_lut(input int ch, input int a, input logic [15:0] d);
        @(negedge clk);
        lut_we   = 1'b1;
        lut_ch   = 2'(ch);
        lut_addr = 8'(a);
        lut_data = d;
        tbl[ch][a] = d;
        @(negedge clk);
        lut_we = 1'b0;
    endtask

    function automatic logic [7:0] seq_caps();
        logic [7:0] c;
        for (int k = 0; k < 4; k++) begin
            if ($urandom_range(0, 11) == 0) c[2*k +: 2] = gen[k] + 2'($urandom_range(1, 3));
            else                            c[2*k +: 2] = gen[k];
            gen[k] = gen[k] + 2'd1;
        end
        return c;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0C1A));
        rst_n = 1'b0; in_valid = 1'b0; in_code = '0; in_cap = '0; in_abort = 1'b0;
        lut_we = 1'b0; lut_ch = '0; lut_addr = '0; lut_data = '0;
        cfg_shift = '0; cfg_mu_lo = 8'd140; cfg_mu_hi = 8'd160;
        for (int c = 0; c < 4; c++) begin
            m_sync[c] = 1'b1; m_exp[c] = '0; gen[c] = '0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0 && out_word == 24'd0, "R9 reset outputs", 32'(out_word), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && out_word == 24'd0, "R9 after reset", 32'(out_word), 32'd0);

        // R2 + R1 directed: single crossing, count latency
        wr_lut(0, 5, 16'd100);
        wr_lut(1, 6, 16'd50);
        wr_lut(2, 7, 16'd0);
        wr_lut(3, 8, 16'd300);
        @(negedge clk);
        in_valid = 1'b1; in_code = {8'd8, 8'd7, 8'd6, 8'd5}; in_cap = 8'b11_10_01_00; in_abort = 1'b1;
        void'(cap_model(in_cap));
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            in_valid = 1'b0; in_abort = 1'b0;
            chk(out_valid == (k == 3), "R1 latency", 32'(out_valid), 32'(k == 3));
        end
        chk(out_word[7:0] == 8'd150, "R2 table values used", 32'(out_word[7:0]), 32'd150);
        chk(out_word[8] == 1'b1, "R6 inside window", 32'(out_word[8]), 32'd1);
        chk(out_word[16:9] == 8'hFF, "R3 saturation", 32'(out_word[16:9]), 32'hFF);
        chk(out_word[18] == 1'b1, "R7 abort", 32'(out_word[18]), 32'd1);
        // keep bench tag generator aligned with model expectation
        for (int c = 0; c < 4; c++) gen[c] = m_exp[c];
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 single result", 32'(out_valid), 32'd0);

        // load all tables
        for (int c = 0; c < 4; c++)
            for (int a = 0; a < 256; a++)
                wr_lut(c, a, tb_fill(c, a));

        // saturation boundary directed: 255 exact, 256 clamps
        wr_lut(2, 1, 16'd200); wr_lut(3, 1, 16'd55);
        wr_lut(2, 2, 16'd200); wr_lut(3, 2, 16'd56);
        wr_lut(0, 0, 16'd0);   wr_lut(1, 0, 16'd0);
        cfg_shift = 4'd0; cfg_mu_lo = 8'd0; cfg_mu_hi = 8'd0;
        step(1'b1, {8'd1, 8'd1, 8'd0, 8'd0}, {gen[3], gen[2], gen[1], gen[0]}, 1'b0);
        for (int c = 0; c < 4; c++) gen[c] = gen[c] + 2'd1;
        step(1'b1, {8'd2, 8'd2, 8'd0, 8'd0}, {gen[3], gen[2], gen[1], gen[0]}, 1'b0);
        for (int c = 0; c < 4; c++) gen[c] = gen[c] + 2'd1;
        drain();

        // R4 directed: lane 0 slips, then resynchronizes on the following tag
        cfg_shift = 4'd4; cfg_mu_lo = 8'd10; cfg_mu_hi = 8'd200;
        begin
            logic [1:0] t0 [6];
            t0[0] = gen[0]; t0[1] = gen[0] + 2'd2; t0[2] = gen[0] + 2'd1;
            t0[3] = gen[0] + 2'd2; t0[4] = gen[0] + 2'd2; t0[5] = gen[0] + 2'd3;
            for (int i = 0; i < 6; i++) begin
                step(1'b1, 32'h40_30_20_10, {gen[3], gen[2], gen[1], t0[i]}, 1'b0);
                for (int c = 1; c < 4; c++) gen[c] = gen[c] + 2'd1;
            end
            gen[0] = t0[5] + 2'd1;
        end
        drain();

        // random phases
        for (int ph = 0; ph < 12; ph++) begin
            cfg_shift = 4'($urandom_range(0, 5));
            cfg_mu_lo = 8'($urandom_range(0, 120));
            cfg_mu_hi = cfg_mu_lo + 8'($urandom_range(0, 120));
            for (int i = 0; i < 150; i++) begin
                bit v;
                v = ($urandom_range(0, 4) != 0);
                if (v) step(1'b1, $urandom(), seq_caps(), ($urandom_range(0, 7) == 0));
                else   step(1'b0, $urandom(), 8'($urandom()), 1'b0);
            end
            drain();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule